// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Invalidation Decoder

This block is a small fully associative cache of page translations. Each entry holds a 20-bit virtual page number (VA bits [31:12], 4 KB pages), the 7-bit address space identifier it belongs to, and a physical frame number. The lookup port is combinational. It returns hit and frame number in the same cycle for an identifier and a 32-bit virtual address. A page walker installs translations through the fill port.

A single register write port carries two 32-bit words. When `wr_sel` is 0 the word is an invalidation command. It removes entries by virtual-address scope: everything, a 4 MB section or a 16 KB group. It can also be limited to a single identifier. When `wr_sel` is 1 the word is the configuration. It holds the number of entries in use, the victim selection policy, and whether lookups keep hitting while an earlier miss is still outstanding.

Top module: `asid_tlb`

## Requirements
- R1: After reset no entry is valid and every lookup misses with `lk_pfn` = 0. The configuration resets to all `ENTRIES` lines in use, round-robin victims on, and hit-under-miss on.
- R2: A lookup hits in the same cycle when a valid, in-use entry has the same identifier and the same VA[31:12]. It then returns that entry's frame number on `lk_pfn`. A different identifier or a different page misses.
- R3: A fill installs identifier, VA page and frame in a victim entry. A fill whose identifier and page already sit in an in-use entry rewrites that entry's frame in place, and the pointer does not move.
- R4: Invalidation word bits [1:0] choose the VA scope, and mode 0 removes entries regardless of address. With bit 31 clear, the identifier is ignored and entries of every identifier are removed.
- R5: With word bit 31 set, only entries whose identifier equals word bits [30:24] are removed.
- R6: Mode 2 removes entries whose VA[31:22] equals word bits [19:10].
- R7: Mode 3 removes entries whose VA[31:14] equals word bits [19:2].
- R8: Mode 1 removes nothing.
- R9: An invalidation takes effect at the clock edge that ends its write cycle. A lookup in that same cycle reports a miss, and a lookup in the following cycle sees the result.
- R10: Configuration bits [5:0] set the number of entries in use, and counts above `ENTRIES` are treated as `ENTRIES`. Entries at or above the count are never filled and never hit. With a count of 0, fills are dropped. Entries left valid above a reduced count hit again once the count is raised.
- R11: Configuration bit 28 set: the victim is the round-robin pointer. The pointer advances only on fills that allocate, and wraps to 0 at the in-use count. Bit 28 clear: the victim is the lowest-numbered free in-use entry, or the pointer when none is free.
- R12: Configuration bit 29 is hit-under-miss. When it is 0, a lookup miss makes every later lookup miss until the next accepted fill.
- R13: A fill and an invalidation in the same cycle: the invalidation acts on the old contents and the newly filled entry ends up valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | 7 | Lookup address space identifier |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit (combinational) |
| lk_pfn | output | PFN_W | Frame number on hit, 0 otherwise |
| fill_valid | input | 1 | Fill request from the page walker |
| fill_asid | input | 7 | Fill identifier |
| fill_vpn | input | 20 | Fill virtual page (VA[31:12]) |
| fill_pfn | input | PFN_W | Fill frame number |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = invalidation word, 1 = configuration word |
| wr_data | input | 32 | Register write data |

## Verification
A lookup can fall in the same cycle as an invalidation write, and a fill can fall in the same cycle as an invalidation. The first case is driven with a no-op invalidation while the lookup targets a valid entry. The result must be a miss in that cycle and a hit one cycle later. The second case issues a fill of a new page together with a full invalidation: the old page must miss afterwards and the new page must hit.

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES = 16,
  parameter int PFN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [6:0]       lk_asid,
  input  logic [31:0]      lk_va,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  input  logic             fill_valid,
  input  logic [6:0]       fill_asid,
  input  logic [19:0]      fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [31:0]      wr_data
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CNT_W = 7;

  logic [ENTRIES-1:0] valid;
  logic [6:0]         tag_asid [ENTRIES];
  logic [19:0]        tag_vpn  [ENTRIES];
  logic [PFN_W-1:0]   tag_pfn  [ENTRIES];

  logic [IDX_W-1:0] ptr;
  logic [CNT_W-1:0] cfg_lines;
  logic             cfg_rr, cfg_hum, miss_pend;

  wire flush_we = wr_en & ~wr_sel;
  wire cfg_we   = wr_en &  wr_sel;
  wire [CNT_W-1:0] act_n = (cfg_lines > CNT_W'(ENTRIES)) ? CNT_W'(ENTRIES) : cfg_lines;

  logic [ENTRIES-1:0] in_use, hit_vec, dup_vec, free_vec, fl_vec;
  logic [PFN_W-1:0]   pfn_or;
  logic [IDX_W-1:0]   dup_idx, free_idx, ptr_eff, victim, ptr_nx;
  logic [CNT_W-1:0]   vic_inc;
  logic               asid_ok, va_ok;

  always_comb begin
    pfn_or = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      in_use[i]   = CNT_W'(i) < act_n;
      hit_vec[i]  = valid[i] & in_use[i] & (tag_asid[i] == lk_asid) & (tag_vpn[i] == lk_va[31:12]);
      dup_vec[i]  = valid[i] & in_use[i] & (tag_asid[i] == fill_asid) & (tag_vpn[i] == fill_vpn);
      free_vec[i] = ~valid[i] & in_use[i];
      asid_ok = ~wr_data[31] | (tag_asid[i] == wr_data[30:24]);
      case (wr_data[1:0])
        2'd0:    va_ok = 1'b1;
        2'd2:    va_ok = tag_vpn[i][19:10] == wr_data[19:10];
        2'd3:    va_ok = tag_vpn[i][19:2] == wr_data[19:2];
        default: va_ok = 1'b0;
      endcase
      fl_vec[i] = flush_we & valid[i] & asid_ok & va_ok;
      if (hit_vec[i]) pfn_or = pfn_or | tag_pfn[i];
    end
  end

  always_comb begin
    dup_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (dup_vec[i])  dup_idx  = IDX_W'(i);
      if (free_vec[i]) free_idx = IDX_W'(i);
    end
  end

  assign ptr_eff = (CNT_W'(ptr) >= act_n) ? '0 : ptr;
  assign victim  = (|dup_vec) ? dup_idx :
                   (cfg_rr || !(|free_vec)) ? ptr_eff : free_idx;
  assign vic_inc = CNT_W'(victim) + CNT_W'(1);
  assign ptr_nx  = (vic_inc >= act_n) ? '0 : IDX_W'(vic_inc);

  wire fill_go = fill_valid & (act_n != '0);
  wire alloc   = fill_go & ~(|dup_vec);

  assign lk_hit = lk_valid & (|hit_vec) & ~flush_we & ~(miss_pend & ~cfg_hum);
  assign lk_pfn = lk_hit ? pfn_or : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid     <= '0;
      ptr       <= '0;
      cfg_lines <= CNT_W'(ENTRIES);
      cfg_rr    <= 1'b1;
      cfg_hum   <= 1'b1;
      miss_pend <= 1'b0;
    end else begin
      if (cfg_we) begin
        cfg_hum   <= wr_data[29];
        cfg_rr    <= wr_data[28];
        cfg_lines <= {1'b0, wr_data[5:0]};
      end
      valid <= valid & ~fl_vec;
      if (fill_go) valid[victim] <= 1'b1;
      if (alloc) ptr <= ptr_nx;
      if (fill_go) miss_pend <= 1'b0;
      else if (lk_valid && !lk_hit) miss_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      tag_asid[victim] <= fill_asid;
      tag_vpn[victim]  <= fill_vpn;
      tag_pfn[victim]  <= fill_pfn;
    end
  end

  p_single_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  p_flush_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_we && wr_data[1:0] == 2'd0 && !wr_data[31] && !fill_valid) |=> (valid == '0));

  p_fill_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && act_n != '0) |=> valid[$past(victim)]);

  p_ptr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_valid |=> $stable(ptr));

  p_zero_lines_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (act_n == '0 && !flush_we) |=> $stable(valid));

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    p_inactive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid[g]) |-> (CNT_W'(g) < $past(act_n)));
  end
endmodule

// File: tb/tb_asid_tlb.sv
`timescale 1ns/1ps
module tb_asid_tlb;
  logic        clk = 0, rst_n = 0;
  logic        lk_valid = 0;
  logic [6:0]  lk_asid = 0;
  logic [31:0] lk_va = 0;
  logic        lk_hit;
  logic [19:0] lk_pfn;
  logic        fill_valid = 0;
  logic [6:0]  fill_asid = 0;
  logic [19:0] fill_vpn = 0, fill_pfn = 0;
  logic        wr_en = 0, wr_sel = 0;
  logic [31:0] wr_data = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  asid_tlb #(.ENTRIES(16), .PFN_W(20)) dut (.*);

  always #2.5 clk = ~clk;

  function automatic logic [31:0] cfg(bit hum, bit rr, int lines);
    return {2'b0, hum, rr, 22'b0, 6'(lines)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(logic [6:0] a, logic [19:0] vpn, logic [19:0] pfn);
    @(negedge clk);
    fill_asid = a; fill_vpn = vpn; fill_pfn = pfn; fill_valid = 1;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic wreg(bit sel, logic [31:0] d);
    @(negedge clk);
    wr_sel = sel; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(string req, logic [6:0] a, logic [19:0] vpn, bit eh, logic [19:0] ep);
    @(negedge clk);
    lk_asid = a; lk_va = {vpn, 12'h5a4}; lk_valid = 1;
    #1;
    chk(req, lk_hit, eh);
    chk(req, lk_pfn, eh ? ep : 20'h0);
    @(posedge clk); #1;
    lk_valid = 0;
  endtask

  task automatic t_reset;
    look("R1 reset miss", 7'd0, 20'h0, 0, 0);
    look("R1 reset miss", 7'd5, 20'h12345, 0, 0);
  endtask

  task automatic t_fill_lookup;
    wreg(0, 32'h0);
    fill(7'd5, 20'h12345, 20'hABCDE);
    look("R2 hit", 7'd5, 20'h12345, 1, 20'hABCDE);
    look("R2 other asid", 7'd6, 20'h12345, 0, 0);
    look("R2 other page", 7'd5, 20'h12346, 0, 0);
    fill(7'd5, 20'h12345, 20'h11111);
    look("R3 refill in place", 7'd5, 20'h12345, 1, 20'h11111);
  endtask

  task automatic t_flush_all;
    fill(7'd1, 20'h00AAA, 20'h1);
    fill(7'd2, 20'h00BBB, 20'h2);
    wreg(0, 32'h0000_0000);
    look("R4 flush all", 7'd1, 20'h00AAA, 0, 0);
    look("R4 flush all other asid", 7'd2, 20'h00BBB, 0, 0);
  endtask

  task automatic t_flush_asid;
    fill(7'd3, 20'h00001, 20'h31);
    fill(7'd4, 20'h00002, 20'h42);
    wreg(0, 32'h8000_0000 | (32'd3 << 24));
    look("R5 asid flushed", 7'd3, 20'h00001, 0, 0);
    look("R5 other asid kept", 7'd4, 20'h00002, 1, 20'h42);
  endtask

  task automatic t_section;
    wreg(0, 32'h0);
    fill(7'd1, 20'h00400, 20'h10);
    fill(7'd2, 20'h007FF, 20'h20);
    fill(7'd1, 20'h00800, 20'h30);
    wreg(0, (32'd1 << 10) | 32'd2);
    look("R6 section low", 7'd1, 20'h00400, 0, 0);
    look("R6 section high", 7'd2, 20'h007FF, 0, 0);
    look("R6 next section kept", 7'd1, 20'h00800, 1, 20'h30);
  endtask

  task automatic t_group;
    wreg(0, 32'h0);
    fill(7'd1, 20'h00100, 20'h61);
    fill(7'd1, 20'h00103, 20'h62);
    fill(7'd1, 20'h00104, 20'h63);
    fill(7'd2, 20'h00101, 20'h64);
    wreg(0, 32'h8000_0000 | (32'd1 << 24) | (32'h40 << 2) | 32'd3);
    look("R7 group first", 7'd1, 20'h00100, 0, 0);
    look("R7 group last", 7'd1, 20'h00103, 0, 0);
    look("R7 next group kept", 7'd1, 20'h00104, 1, 20'h63);
    look("R7 other asid kept", 7'd2, 20'h00101, 1, 20'h64);
  endtask

  task automatic t_same_cycle;
    wreg(0, 32'h0);
    fill(7'd9, 20'h0CAFE, 20'h77);
    @(negedge clk);
    wr_sel = 0; wr_data = 32'h1; wr_en = 1;
    lk_asid = 7'd9; lk_va = {20'h0CAFE, 12'h0}; lk_valid = 1;
    #1;
    chk("R9 lookup during flush", lk_hit, 0);
    @(posedge clk); #1;
    wr_en = 0; lk_valid = 0;
    look("R8 mode1 keeps entry", 7'd9, 20'h0CAFE, 1, 20'h77);
  endtask

  task automatic t_fill_flush;
    fill(7'd9, 20'h0BEEF, 20'h88);
    @(negedge clk);
    fill_asid = 7'd9; fill_vpn = 20'h0D00D; fill_pfn = 20'h99; fill_valid = 1;
    wr_sel = 0; wr_data = 32'h0; wr_en = 1;
    @(negedge clk);
    fill_valid = 0; wr_en = 0;
    look("R13 old removed", 7'd9, 20'h0BEEF, 0, 0);
    look("R13 new kept", 7'd9, 20'h0D00D, 1, 20'h99);
  endtask

  task automatic t_active;
    wreg(0, 32'h0);
    wreg(1, cfg(1, 1, 2));
    fill(7'd1, 20'h00001, 20'hA);
    fill(7'd1, 20'h00002, 20'hB);
    fill(7'd1, 20'h00003, 20'hC);
    look("R11 oldest evicted", 7'd1, 20'h00001, 0, 0);
    look("R10 two lines", 7'd1, 20'h00002, 1, 20'hB);
    look("R10 two lines", 7'd1, 20'h00003, 1, 20'hC);
    wreg(1, cfg(1, 1, 0));
    look("R10 zero lines no hit", 7'd1, 20'h00003, 0, 0);
    fill(7'd1, 20'h00004, 20'hD);
    wreg(1, cfg(1, 1, 16));
    look("R10 reactivated", 7'd1, 20'h00003, 1, 20'hC);
    look("R10 dropped fill", 7'd1, 20'h00004, 0, 0);
  endtask

  task automatic t_clamp;
    wreg(0, 32'h0);
    wreg(1, cfg(1, 1, 63));
    for (int k = 0; k < 17; k++) fill(7'd2, 20'h00100 + 20'(k), 20'h50 + 20'(k));
    look("R10 clamp evicts first", 7'd2, 20'h00100, 0, 0);
    look("R11 wrap kept", 7'd2, 20'h00101, 1, 20'h51);
    look("R11 wrap last", 7'd2, 20'h00110, 1, 20'h60);
  endtask

  task automatic t_lowest_free;
    wreg(0, 32'h0);
    wreg(1, cfg(1, 0, 4));
    fill(7'd1, 20'h00010, 20'h1);
    fill(7'd2, 20'h00020, 20'h2);
    fill(7'd1, 20'h00030, 20'h3);
    fill(7'd1, 20'h00040, 20'h4);
    wreg(0, 32'h8000_0000 | (32'd2 << 24));
    fill(7'd1, 20'h00050, 20'h5);
    look("R11 free slot A", 7'd1, 20'h00010, 1, 20'h1);
    look("R11 free slot C", 7'd1, 20'h00030, 1, 20'h3);
    look("R11 free slot D", 7'd1, 20'h00040, 1, 20'h4);
    look("R11 free slot E", 7'd1, 20'h00050, 1, 20'h5);
    look("R5 flushed B", 7'd2, 20'h00020, 0, 0);
  endtask

  task automatic t_hum;
    wreg(0, 32'h0);
    wreg(1, cfg(0, 1, 16));
    fill(7'd3, 20'h00A00, 20'hAA);
    look("R12 first miss", 7'd3, 20'h00B00, 0, 0);
    look("R12 blocked after miss", 7'd3, 20'h00A00, 0, 0);
    fill(7'd3, 20'h00C00, 20'hCC);
    look("R12 released by fill", 7'd3, 20'h00A00, 1, 20'hAA);
    wreg(1, cfg(1, 1, 16));
    look("R12 miss with hum", 7'd3, 20'h00B00, 0, 0);
    look("R12 hit under miss", 7'd3, 20'h00A00, 1, 20'hAA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fill_lookup();
    t_flush_all();
    t_flush_asid();
    t_section();
    t_group();
    t_same_cycle();
    t_fill_flush();
    t_active();
    t_clamp();
    t_lowest_free();
    t_hum();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule